// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This block is a DSP datapath that multiplies signed operands and adds a 32-bit accumulate value in a single registered step. It has two modes. In the halfword mode, one signed 16-bit half of operand A is multiplied by one signed 16-bit half of operand B, and the accumulate value is added to the 32-bit product. In the word mode, all 32 bits of A are multiplied by a signed half of B. The accumulate value is then added to the upper 32 bits of the 48-bit product, so the lowest 16 product bits are dropped.

A valid strobe qualifies each operation. The result appears on the output register one clock later. A signed overflow in the accumulate addition does not saturate the result. The 32-bit sum wraps, and a sticky saturation flag is raised instead. The flag is held by a two-state machine: `FLAG_CLEAR` moves to `FLAG_HELD` on a qualified overflow, and `FLAG_HELD` moves back to `FLAG_CLEAR` only on a clear pulse that does not coincide with a qualified overflow. Any other combination keeps the current state.

Top module: `hmac_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `result` and `sat_flag` are all 0.
- R2: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high. When `in_valid` is low, `result` keeps its previous value.
- R3: In halfword mode (`mode`=0), `sel_a_top`=0 picks `op_a[15:0]` and `sel_a_top`=1 picks `op_a[31:16]`. The picked half is read as signed.
- R4: In both modes, `sel_b_top`=0 picks `op_b[15:0]` and `sel_b_top`=1 picks `op_b[31:16]` as the signed 16-bit second factor.
- R5: In halfword mode, `result` = signed(half A) × signed(half B) + `acc`, taken modulo 2^32. The halves that were not picked have no effect on the result.
- R6: In word mode (`mode`=1), `result` = bits [47:16] of signed(`op_a`) × signed(half B), plus `acc`, taken modulo 2^32.
- R7: On overflow, `result` is the wrapped 32-bit two's-complement sum and is never clamped. For example, (-32768)×(-32768) + 0x40000000 gives 0x80000000.
- R8: A qualified operation whose true sum lies outside [-2^31, 2^31-1] sets `sat_flag`. The flag is visible one clock after the operation is sampled.
- R9: Once set, `sat_flag` stays set through operations that do not overflow.
- R10: A `sat_clr` pulse clears `sat_flag` one clock later. If the pulse falls in the same cycle as a qualified overflowing operation, the flag ends up set.
- R11: While `in_valid` is low, `sat_flag` ignores whatever the operand inputs would produce. With no `sat_clr`, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operation on this cycle |
| mode | input | 1 | 0 = halfword × halfword, 1 = word × halfword |
| sel_a_top | input | 1 | Halfword mode: selects the upper half of `op_a` |
| sel_b_top | input | 1 | Selects the upper half of `op_b` |
| op_a | input | 32 | First multiply operand |
| op_b | input | 32 | Second multiply operand |
| acc | input | 32 | Accumulate operand |
| sat_clr | input | 1 | Pulse that clears the sticky flag |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Wrapped multiply-accumulate result |
| sat_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
A clear pulse and a qualified overflowing operation can arrive in the same cycle, and the flag machine must then favour the new overflow. The bench first sets the flag with the (-32768)×(-32768) + 0x40000000 case. It then drives a second overflowing operation with `sat_clr` high in that same cycle and expects the flag to stay set. A clear paired with a non-overflowing operation must instead drop the flag. The scoreboard judges each case from its own model of the flag, updated as "overflow OR (old flag AND NOT clear)".

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    typedef enum logic {
        MODE_HH = 1'b0,
        MODE_WH = 1'b1
    } hmac_mode_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } hmac_flag_e;

endpackage

// File: rtl/hmac_half_pick.sv
module hmac_half_pick #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic              pick_top,
    output logic [HALF_W-1:0] half_out
);
    always_comb begin
        half_out = pick_top ? word_in[DATA_W-1:HALF_W] : word_in[HALF_W-1:0];
    end
endmodule

// File: rtl/hmac_product.sv
module hmac_product
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int PROD_W = DATA_W + HALF_W
) (
    input  hmac_mode_e        mode,
    input  logic [DATA_W-1:0] a_word,
    input  logic [HALF_W-1:0] a_half,
    input  logic [HALF_W-1:0] b_half,
    output logic [DATA_W-1:0] addend
);
    logic signed [DATA_W-1:0] a_half_x;
    logic signed [DATA_W-1:0] b_half_x;
    logic signed [DATA_W-1:0] hh_prod;
    logic signed [PROD_W-1:0] a_word_x;
    logic signed [PROD_W-1:0] b_half_w;
    logic signed [PROD_W-1:0] wh_prod;

    always_comb begin
        a_half_x = $signed({{HALF_W{a_half[HALF_W-1]}}, a_half});
        b_half_x = $signed({{HALF_W{b_half[HALF_W-1]}}, b_half});
        hh_prod  = a_half_x * b_half_x;
        a_word_x = $signed({{HALF_W{a_word[DATA_W-1]}}, a_word});
        b_half_w = $signed({{DATA_W{b_half[HALF_W-1]}}, b_half});
        wh_prod  = a_word_x * b_half_w;
        unique case (mode)
            MODE_HH: addend = hh_prod;
            MODE_WH: addend = wh_prod[PROD_W-1:HALF_W];
            default: addend = '0;
        endcase
    end
endmodule

// File: rtl/hmac_acc_add.sv
module hmac_acc_add #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] addend,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        sum = addend + acc;
        ovf = (addend[MSB] == acc[MSB]) && (sum[MSB] != addend[MSB]);
    end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode,
    input  logic              sel_a_top,
    input  logic              sel_b_top,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] acc,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int HALF_W = DATA_W / 2;

    hmac_mode_e        mode_e;
    logic              a_pick_top;
    logic [HALF_W-1:0] a_half;
    logic [HALF_W-1:0] b_half;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    logic              ovf;
    logic              set_evt;
    hmac_flag_e        flag_q;
    hmac_flag_e        flag_d;

    always_comb begin
        mode_e     = hmac_mode_e'(mode);
        a_pick_top = (mode_e == MODE_HH) && sel_a_top;
        set_evt    = in_valid && ovf;
    end

    hmac_half_pick #(.DATA_W(DATA_W)) u_pick_a (
        .word_in  (op_a),
        .pick_top (a_pick_top),
        .half_out (a_half)
    );

    hmac_half_pick #(.DATA_W(DATA_W)) u_pick_b (
        .word_in  (op_b),
        .pick_top (sel_b_top),
        .half_out (b_half)
    );

    hmac_product #(.DATA_W(DATA_W)) u_prod (
        .mode   (mode_e),
        .a_word (op_a),
        .a_half (a_half),
        .b_half (b_half),
        .addend (addend)
    );

    hmac_acc_add #(.DATA_W(DATA_W)) u_add (
        .addend (addend),
        .acc    (acc),
        .sum    (sum),
        .ovf    (ovf)
    );

    // Datapath output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sum;
            end
        end
    end

    // Flag state register
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= FLAG_CLEAR;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Flag next state
    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLAG_CLEAR: if (set_evt) flag_d = FLAG_HELD;
            FLAG_HELD:  if (sat_clr && !set_evt) flag_d = FLAG_CLEAR;
            default:    flag_d = FLAG_CLEAR;
        endcase
    end

    // Flag output
    always_comb begin
        sat_flag = (flag_q == FLAG_HELD);
    end
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              mode,
    input logic              sel_a_top,
    input logic              sel_b_top,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] acc,
    input logic              sat_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    logic [DATA_W-1:0] unused_xor;
    always_comb unused_xor = op_a ^ op_b ^ acc ^ {{(DATA_W-3){1'b0}}, mode, sel_a_top, sel_b_top};

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && !sat_flag && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst) (sat_flag && !sat_clr) |=> sat_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst) (sat_clr && !in_valid) |=> !sat_flag);

    // R11
    flag_idle_chk: assert property (@(posedge clk) disable iff (rst) (!in_valid && !sat_clr) |=> $stable(sat_flag));
endmodule

bind hmac_unit hmac_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .sel_a_top (sel_a_top),
    .sel_b_top (sel_b_top),
    .op_a      (op_a),
    .op_b      (op_b),
    .acc       (acc),
    .sat_clr   (sat_clr),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/hmac_unit_bench.sv
module hmac_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        mode;
    logic        sel_a_top;
    logic        sel_b_top;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] acc;
    logic        sat_clr;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic model_flag = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        flg;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    hmac_unit u_hmac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .sel_a_top(sel_a_top), .sel_b_top(sel_b_top),
        .op_a(op_a), .op_b(op_b), .acc(acc), .sat_clr(sat_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] ref_calc(input logic m, input logic sa, input logic sb,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c);
        longint ha;
        longint hb;
        longint p;
        longint s;
        logic   o;
        ha = sa ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
        hb = sb ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
        if (!m) p = ha * hb;
        else    p = (longint'($signed(a)) * hb) >>> 16;
        s = p + longint'($signed(c));
        o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {o, s[31:0]};
    endfunction

    task automatic issue(input logic m, input logic sa, input logic sb,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic clr, input string tag);
        logic [32:0] r;
        exp_t        e;
        r = ref_calc(m, sa, sb, a, b, c);
        model_flag = r[32] | (model_flag & ~clr);
        e.res = r[31:0];
        e.flg = model_flag;
        e.tag = tag;
        sb_q.push_back(e);
        in_valid = 1'b1; mode = m; sel_a_top = sa; sel_b_top = sb;
        op_a = a; op_b = b; acc = c; sat_clr = clr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; sat_clr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", {31'd0, out_valid}, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(result === e.res, {e.tag, " result"}, result, e.res);
                check(sat_flag === e.flg, {e.tag, " sat_flag"}, {31'd0, sat_flag}, {31'd0, e.flg});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rst = 1'b1; in_valid = 1'b0; mode = 1'b0; sel_a_top = 1'b0; sel_b_top = 1'b0;
        op_a = '0; op_b = '0; acc = '0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!out_valid && result == 0 && !sat_flag, "R1 reset", result, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && result == 0 && !sat_flag, "R1 after reset", result, 32'd0);

        // R3 R4 R5 all four half selections, halfword mode
        issue(1'b0, 1'b0, 1'b0, 32'h7123_0005, 32'hFFFD_0007, 32'd100, 1'b0, "R3 R4 R5 BB");
        issue(1'b0, 1'b0, 1'b1, 32'h7123_FFF0, 32'h0033_0007, 32'hFFFF_FF00, 1'b0, "R3 R4 R5 BT");
        issue(1'b0, 1'b1, 1'b0, 32'h8001_1234, 32'h5555_FF80, 32'd7, 1'b0, "R3 R4 R5 TB");
        issue(1'b0, 1'b1, 1'b1, 32'h0400_9999, 32'hFC00_1111, 32'h0010_0000, 1'b0, "R3 R4 R5 TT");
        // R5 unpicked halves changed, same picked halves
        issue(1'b0, 1'b0, 1'b0, 32'hABCD_0005, 32'h1357_0007, 32'd100, 1'b0, "R5 unpicked ignored");
        idle(2);

        // R4 R6 word mode, both B selections
        issue(1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0100, 32'd3, 1'b0, "R4 R6 B bottom");
        issue(1'b1, 1'b1, 1'b1, 32'hFEDC_BA98, 32'h8000_0010, 32'hFFFF_0000, 1'b0, "R4 R6 B top");
        issue(1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'd0, 1'b0, "R6 A min B min");
        issue(1'b1, 1'b0, 1'b1, 32'h8000_0000, 32'h0001_0000, 32'd9, 1'b0, "R6 A min B one");
        idle(2);

        // R7 R8 wrap and flag set
        issue(1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 1'b0, "R7 R8 max product overflow");
        // R9 no-overflow op keeps flag
        issue(1'b0, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'd1, 1'b0, "R9 sticky");
        idle(1);

        // R10 clear alone
        sat_clr = 1'b1; in_valid = 1'b0; model_flag = 1'b0;
        @(negedge clk);
        sat_clr = 1'b0;
        check(sat_flag == 1'b0, "R10 clear only", {31'd0, sat_flag}, 32'd0);

        // R8 negative overflow in word mode
        issue(1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 1'b0, "R7 R8 negative wrap");
        // R10 clear in same cycle as overflow: stays set
        issue(1'b0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h7000_0000, 1'b1, "R10 clear with overflow");
        // R10 clear with non-overflow op: drops
        issue(1'b0, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0004, 32'd4, 1'b1, "R10 clear with plain op");
        idle(2);

        // R11 overflow-producing inputs without valid
        held = result;
        in_valid = 1'b0; mode = 1'b0; sel_a_top = 1'b0; sel_b_top = 1'b0;
        op_a = 32'h0000_8000; op_b = 32'h0000_8000; acc = 32'h7FFF_FFFF;
        repeat (2) @(negedge clk);
        check(sat_flag == 1'b0, "R11 flag ignores idle inputs", {31'd0, sat_flag}, 32'd0);
        check(result == held && !out_valid, "R2 result held while idle", result, held);

        // R2 back-to-back stream after gap
        issue(1'b1, 1'b1, 1'b1, 32'h0001_0000, 32'h0002_0000, 32'd5, 1'b0, "R2 stream 0");
        issue(1'b0, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 32'd5, 1'b0, "R2 stream 1");
        issue(1'b0, 1'b0, 1'b1, 32'h0000_7FFF, 32'h7FFF_0000, 32'h8000_0000, 1'b0, "R2 stream 2");
        idle(3);
        check(sb_q.size() == 0, "R2 all results delivered", sb_q.size(), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule